// File: doc/BRIEF.md
# Domain and Permission Access Checker

This block decides, for a memory access that has already hit in the translation buffer, whether the access may go ahead or must be aborted. The check runs in two levels. First, the entry's 4-bit domain number picks one 2-bit field out of a 32-bit domain control register. That field can abort the access outright, allow it outright, or hand the decision to the page permission bits. In the last case the permission field is taken from the entry. Large and small pages carry four permission fields, one per subpage, and the virtual address picks one of them. Sections and tiny pages use a single field.

One cycle after a request is presented, the block gives a response. The response says whether the access was allowed or aborted and, for an abort, whether it was a domain fault or a permission fault. An allowed access to a non-cacheable region also raises an off-chip request and puts the entry's physical address on the output. Software writes the domain control register through a simple write port.

The block is built around a four-state machine that holds the verdict of the previous cycle:
- ST_IDLE: no response this cycle.
- ST_GRANT: the access is allowed.
- ST_DOMFLT: the access is aborted by its domain.
- ST_PERMFLT: the access is aborted by its page permissions.

The next state depends only on the request in the current cycle:
- T_NOREQ: any state goes to ST_IDLE when no request is present.
- T_DOMDENY: any state goes to ST_DOMFLT when the domain field is no-access or reserved.
- T_ALLOW: any state goes to ST_GRANT when the domain field is manager, or client with a passing permission check.
- T_PERMDENY: any state goes to ST_PERMFLT when the domain field is client and the permission check fails.

Top module: `acc_chk`

## Requirements
- R1: After reset, rsp_valid is 0 and the domain control register is all zeros, so every domain aborts with a domain fault.
- R2: Domain d's field sits at bits [2d+1:2d] of the domain control register. A write takes effect from the cycle after dacr_we. An access in the same cycle as the write uses the old value.
- R3: A domain field of 00 (no access) or 10 (reserved) aborts the access with fault code 01 (domain fault), whatever the permission bits are.
- R4: A domain field of 11 (manager) allows the access, whatever the permission bits, the access type and the privilege are.
- R5: A domain field of 01 (client) checks the selected 2-bit permission field. 00 denies everything. 01 allows privileged access only. 10 allows privileged access of either type and user reads. 11 allows everything. A denial gives fault code 10 (permission fault).
- R6: Page size code 00 is a section, 01 a large page, 10 a small page and 11 a tiny page. The permission field is req_ap[2k+1:2k]. For a large page, k is VA[15:14] (req_vsub[5:4]). For a small page, k is VA[11:10] (req_vsub[1:0]). For sections and tiny pages, k is 0.
- R7: rsp_valid is 1 exactly in the cycle after a cycle with req_valid set. In cycles without a response, all result outputs are 0.
- R8: rsp_offchip is 1 only for an allowed access whose entry is non-cacheable. rsp_pa carries the entry's physical address when rsp_offchip is 1, and is 0 otherwise.
- R9: On a valid response, exactly one of rsp_allow and rsp_abort is 1. The fault code is 00 when the access is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dacr_we | input | 1 | Write strobe for the domain control register |
| dacr_wdata | input | 32 | New domain control register value |
| req_valid | input | 1 | Access request present |
| req_domain | input | 4 | Domain number of the matching entry |
| req_ap | input | 8 | Four 2-bit permission fields of the entry |
| req_size | input | 2 | Page size code |
| req_vsub | input | 6 | Virtual address bits 15 to 10 |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_priv | input | 1 | 1 for a privileged access |
| req_cacheable | input | 1 | Cacheable attribute of the entry |
| req_pa | input | 32 | Physical address from the entry |
| rsp_valid | output | 1 | Response present |
| rsp_allow | output | 1 | Access allowed |
| rsp_abort | output | 1 | Access aborted |
| rsp_fault | output | 2 | 00 none, 01 domain fault, 10 permission fault |
| rsp_offchip | output | 1 | Allowed access needs memory outside the chip |
| rsp_pa | output | 32 | Physical address for the off-chip access |

## Verification
A wrong domain control register value does not show up until an access uses the affected domain. It then shows in the next cycle as an abort where a grant was due, or the reverse. For that reason every domain encoding is exercised right after each write, including an access in the same cycle as the write. If the subpage multiplexer picks the wrong field, or a permission decode entry is wrong, the error shows in the very next response as a grant that should have been a permission fault, or the reverse. The sweep therefore sets the unselected subpage address bits to the complement of the selected ones, so that a wrong selection produces a different result. A stale cacheable bit or physical address register shows in the same response on rsp_offchip and rsp_pa.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [1:0] {
        DOM_NONE    = 2'b00,
        DOM_CLIENT  = 2'b01,
        DOM_RSVD    = 2'b10,
        DOM_MANAGER = 2'b11
    } dom_mode_e;

    typedef enum logic [1:0] {
        PG_SECTION = 2'b00,
        PG_LARGE   = 2'b01,
        PG_SMALL   = 2'b10,
        PG_TINY    = 2'b11
    } pg_size_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_DOMAIN = 2'b01,
        FLT_PERM   = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_GRANT   = 2'd1,
        ST_DOMFLT  = 2'd2,
        ST_PERMFLT = 2'd3
    } chk_state_e;

    localparam int FIELD_W = 2;

endpackage

// File: rtl/acc_dom_sel.sv
module acc_dom_sel
    import acc_pkg::*;
#(
    parameter int NDOM = 16,
    localparam int DOMW = $clog2(NDOM),
    localparam int REGW = NDOM * FIELD_W
) (
    input  logic [REGW-1:0] dacr,
    input  logic [DOMW-1:0] dom,
    output dom_mode_e       mode
);

    logic [FIELD_W-1:0] fields [NDOM];

    // Split the control word into one field per domain.
    for (genvar g = 0; g < NDOM; g++) begin : g_fld
        assign fields[g] = dacr[g*FIELD_W +: FIELD_W];
    end

    assign mode = dom_mode_e'(fields[dom]);

endmodule

// File: rtl/acc_perm_sel.sv
module acc_perm_sel
    import acc_pkg::*;
#(
    parameter int NSUB = 4,
    localparam int SUBW = $clog2(NSUB),
    localparam int APW  = NSUB * FIELD_W
) (
    input  logic [APW-1:0]    ap,
    input  pg_size_e          size,
    input  logic [SUBW-1:0]   sub_large,
    input  logic [SUBW-1:0]   sub_small,
    input  logic              write,
    input  logic              priv,
    output logic              perm_ok
);

    logic [FIELD_W-1:0] ap_f [NSUB];
    logic [SUBW-1:0]    idx;
    logic [FIELD_W-1:0] sel;

    for (genvar g = 0; g < NSUB; g++) begin : g_ap
        assign ap_f[g] = ap[g*FIELD_W +: FIELD_W];
    end

    // The page size decides which address bits pick the subpage.
    always_comb begin
        unique case (size)
            PG_LARGE: idx = sub_large;
            PG_SMALL: idx = sub_small;
            default:  idx = '0;
        endcase
    end

    assign sel = ap_f[idx];

    always_comb begin
        unique case (sel)
            2'b00:   perm_ok = 1'b0;
            2'b01:   perm_ok = priv;
            2'b10:   perm_ok = priv | ~write;
            default: perm_ok = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_chk.sv
module acc_chk
    import acc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NDOM = 16,
    parameter int NSUB = 4,
    localparam int DOMW = $clog2(NDOM),
    localparam int REGW = NDOM * FIELD_W,
    localparam int SUBW = $clog2(NSUB),
    localparam int APW  = NSUB * FIELD_W,
    localparam int VSW  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            dacr_we,
    input  logic [REGW-1:0] dacr_wdata,
    input  logic            req_valid,
    input  logic [DOMW-1:0] req_domain,
    input  logic [APW-1:0]  req_ap,
    input  logic [1:0]      req_size,
    input  logic [VSW-1:0]  req_vsub,
    input  logic            req_write,
    input  logic            req_priv,
    input  logic            req_cacheable,
    input  logic [AW-1:0]   req_pa,
    output logic            rsp_valid,
    output logic            rsp_allow,
    output logic            rsp_abort,
    output logic [1:0]      rsp_fault,
    output logic            rsp_offchip,
    output logic [AW-1:0]   rsp_pa
);

    logic [REGW-1:0] dacr_q;
    dom_mode_e       dom_mode;
    logic            perm_ok;
    chk_state_e      state_q, state_d;
    logic            cach_q;
    logic [AW-1:0]   pa_q;

    // Domain control register.
    always_ff @(posedge clk) begin
        if (!rst_n) dacr_q <= '0;
        else if (dacr_we) dacr_q <= dacr_wdata;
    end

    acc_dom_sel #(.NDOM(NDOM)) u_dom (
        .dacr (dacr_q),
        .dom  (req_domain),
        .mode (dom_mode)
    );

    // VA[15:14] and VA[11:10] sit at the top and bottom of req_vsub.
    acc_perm_sel #(.NSUB(NSUB)) u_perm (
        .ap        (req_ap),
        .size      (pg_size_e'(req_size)),
        .sub_large (req_vsub[VSW-1 -: SUBW]),
        .sub_small (req_vsub[SUBW-1:0]),
        .write     (req_write),
        .priv      (req_priv),
        .perm_ok   (perm_ok)
    );

    // Next-state logic.
    always_comb begin
        if (!req_valid) begin
            state_d = ST_IDLE;                       // T_NOREQ
        end else begin
            unique case (dom_mode)
                DOM_MANAGER: state_d = ST_GRANT;     // T_ALLOW
                DOM_CLIENT:  state_d = perm_ok ? ST_GRANT      // T_ALLOW
                                               : ST_PERMFLT;   // T_PERMDENY
                default:     state_d = ST_DOMFLT;    // T_DOMDENY
            endcase
        end
    end

    // State register, with the attributes the response needs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cach_q  <= 1'b0;
            pa_q    <= '0;
        end else begin
            state_q <= state_d;
            cach_q  <= req_cacheable;
            pa_q    <= req_pa;
        end
    end

    // Outputs decoded from the state.
    always_comb begin
        rsp_valid   = 1'b1;
        rsp_allow   = 1'b0;
        rsp_abort   = 1'b0;
        rsp_fault   = FLT_NONE;
        rsp_offchip = 1'b0;
        rsp_pa      = '0;
        unique case (state_q)
            ST_IDLE:    rsp_valid = 1'b0;
            ST_GRANT: begin
                rsp_allow   = 1'b1;
                rsp_offchip = ~cach_q;
                rsp_pa      = cach_q ? '0 : pa_q;
            end
            ST_DOMFLT: begin
                rsp_abort = 1'b1;
                rsp_fault = FLT_DOMAIN;
            end
            ST_PERMFLT: begin
                rsp_abort = 1'b1;
                rsp_fault = FLT_PERM;
            end
        endcase
    end

endmodule

// File: rtl/acc_chk_sva.sv
module acc_chk_sva
    import acc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int NDOM = 16,
    localparam int DOMW = $clog2(NDOM),
    localparam int REGW = NDOM * FIELD_W
) (
    input logic            clk,
    input logic            rst_n,
    input logic            dacr_we,
    input logic [REGW-1:0] dacr_wdata,
    input logic [REGW-1:0] dacr_q,
    input logic            req_valid,
    input logic [DOMW-1:0] req_domain,
    input logic            rsp_valid,
    input logic            rsp_allow,
    input logic            rsp_abort,
    input logic [1:0]      rsp_fault,
    input logic            rsp_offchip,
    input logic [AW-1:0]   rsp_pa
);

    // R7
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R7
    no_resp_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R9
    one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_allow ^ rsp_abort));

    // R9
    grant_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> (rsp_fault == FLT_NONE));

    // R8
    offchip_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_offchip |-> rsp_allow);

    // R8
    pa_zero_onchip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_offchip |-> (rsp_pa == '0));

    // R2
    dacr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dacr_we |=> (dacr_q == $past(dacr_wdata)));

    // R3
    domain_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !dacr_q[2*req_domain]) |=> (rsp_abort && rsp_fault == FLT_DOMAIN));

    // R4
    manager_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && dacr_q[2*req_domain +: 2] == 2'b11) |=> rsp_allow);

endmodule

bind acc_chk acc_chk_sva #(.AW(AW), .NDOM(NDOM)) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .dacr_we     (dacr_we),
    .dacr_wdata  (dacr_wdata),
    .dacr_q      (dacr_q),
    .req_valid   (req_valid),
    .req_domain  (req_domain),
    .rsp_valid   (rsp_valid),
    .rsp_allow   (rsp_allow),
    .rsp_abort   (rsp_abort),
    .rsp_fault   (rsp_fault),
    .rsp_offchip (rsp_offchip),
    .rsp_pa      (rsp_pa)
);

// File: tb/sim_acc_chk.sv
`timescale 1ns/1ps
module sim_acc_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dacr_we = 1'b0;
    logic [31:0] dacr_wdata = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_domain = '0;
    logic [7:0]  req_ap = '0;
    logic [1:0]  req_size = '0;
    logic [5:0]  req_vsub = '0;
    logic        req_write = 1'b0;
    logic        req_priv = 1'b0;
    logic        req_cacheable = 1'b0;
    logic [31:0] req_pa = '0;
    logic        rsp_valid, rsp_allow, rsp_abort, rsp_offchip;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_pa;

    always #10 clk = ~clk;

    acc_chk u0 (
        .clk(clk), .rst_n(rst_n), .dacr_we(dacr_we), .dacr_wdata(dacr_wdata),
        .req_valid(req_valid), .req_domain(req_domain), .req_ap(req_ap),
        .req_size(req_size), .req_vsub(req_vsub), .req_write(req_write),
        .req_priv(req_priv), .req_cacheable(req_cacheable), .req_pa(req_pa),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_abort(rsp_abort),
        .rsp_fault(rsp_fault), .rsp_offchip(rsp_offchip), .rsp_pa(rsp_pa)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model_dacr = '0;
    logic [37:0] exp_q [$];
    string       tag_q [$];

    // Expected response {valid, allow, abort, fault, offchip, pa}.
    function automatic logic [37:0] expect_rsp(logic [31:0] d, logic v, logic [3:0] dom,
            logic [7:0] ap, logic [1:0] sz, logic [5:0] vs, logic wr, logic pv,
            logic ca, logic [31:0] pa);
        logic [1:0] dm, f;
        logic [1:0] k;
        logic ok;
        if (!v) return '0;
        dm = d[2*dom +: 2];
        if (dm == 2'b11) ok = 1'b1;
        else if (dm == 2'b01) begin
            k = (sz == 2'b01) ? vs[5:4] : (sz == 2'b10) ? vs[1:0] : 2'b00;
            f = ap[2*k +: 2];
            ok = (f == 2'b11) || (f == 2'b01 && pv) || (f == 2'b10 && (pv || !wr));
            if (!ok) return {1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 32'h0};
        end else return {1'b1, 1'b0, 1'b1, 2'b01, 1'b0, 32'h0};
        return {1'b1, 1'b1, 1'b0, 2'b00, !ca, ca ? 32'h0 : pa};
    endfunction

    task automatic drive(logic v, logic [3:0] dom, logic [7:0] ap, logic [1:0] sz,
            logic [5:0] vs, logic wr, logic pv, logic ca, logic [31:0] pa,
            logic we, logic [31:0] wd, string tag);
        req_valid = v; req_domain = dom; req_ap = ap; req_size = sz;
        req_vsub = vs; req_write = wr; req_priv = pv; req_cacheable = ca;
        req_pa = pa; dacr_we = we; dacr_wdata = wd;
        exp_q.push_back(expect_rsp(model_dacr, v, dom, ap, sz, vs, wr, pv, ca, pa));
        tag_q.push_back(tag);
        if (we) model_dacr = wd;
        @(negedge clk);
    endtask

    task automatic idle();
        drive(1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b0, '0, "R7");
    endtask

    // Monitor: pops one expected item per cycle after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (exp_q.size() > 0) begin
                logic [37:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {rsp_valid, rsp_allow, rsp_abort, rsp_fault, rsp_offchip, rsp_pa};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s actual=%h expected=%h", t, a, e);
                end
            end
        end
    end

    initial begin
        #3000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [5:0] vs;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 actual=%b expected=0", rsp_valid);
        end
        // R1: cleared register gives domain faults.
        drive(1'b1, 4'd5, 8'hFF, 2'b00, '0, 1'b0, 1'b1, 1'b0, 32'h1234, 1'b0, '0, "R1");
        drive(1'b1, 4'd15, 8'hFF, 2'b11, '0, 1'b1, 1'b1, 1'b1, 32'h0, 1'b0, '0, "R1");
        idle();
        // R2: write and access in the same cycle use the old value, then the new one.
        drive(1'b1, 4'd1, 8'hFF, 2'b00, '0, 1'b0, 1'b1, 1'b0, 32'hA000_0000,
              1'b1, 32'hE4E4_E4E4, "R2");
        drive(1'b1, 4'd1, 8'hFF, 2'b00, '0, 1'b0, 1'b1, 1'b0, 32'hA000_0000,
              1'b0, '0, "R2");
        drive(1'b1, 4'd3, 8'h00, 2'b00, '0, 1'b1, 1'b0, 1'b0, 32'hA000_0004,
              1'b0, '0, "R4");
        // Sweep domain encodings, page sizes, subpages, access type and privilege.
        for (int dm = 0; dm < 4; dm++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int sb = 0; sb < 4; sb++) begin
                    for (int rot = 0; rot < 4; rot++) begin
                        for (int m = 0; m < 8; m++) begin
                            logic [7:0] ap;
                            string t;
                            ap = 8'hE4;
                            ap = (ap << (2*rot)) | (ap >> (8 - 2*rot));
                            vs = (sz == 1) ? {sb[1:0], 2'b00, ~sb[1:0]} : {~sb[1:0], 2'b00, sb[1:0]};
                            t = (dm == 0 || dm == 2) ? "R3" : (dm == 3) ? "R4" :
                                (sz == 1 || sz == 2) ? "R6" : "R5";
                            if (m[2]) t = {t, "/R8"};
                            drive(1'b1, 4'(dm + 4*sb), ap, sz[1:0], vs, m[0], m[1], m[2],
                                  32'h8000_0000 + 32'(dm*256 + sb*16 + m), 1'b0, '0, t);
                        end
                    end
                end
            end
            if (dm == 1) idle();
        end
        // R2: new pattern flips fields; domain 0 becomes client, domain 2 manager.
        drive(1'b0, '0, '0, '0, '0, 1'b0, 1'b0, 1'b0, '0, 1'b1, 32'h0000_0031, "R2");
        drive(1'b1, 4'd0, 8'h01, 2'b10, 6'h00, 1'b0, 1'b0, 1'b0, 32'h55, 1'b0, '0, "R5");
        drive(1'b1, 4'd0, 8'h01, 2'b10, 6'h00, 1'b1, 1'b1, 1'b0, 32'h56, 1'b0, '0, "R5");
        drive(1'b1, 4'd2, 8'h00, 2'b01, 6'h3F, 1'b1, 1'b0, 1'b0, 32'h57, 1'b0, '0, "R4/R8");
        drive(1'b1, 4'd1, 8'hFF, 2'b01, 6'h3F, 1'b1, 1'b1, 1'b0, 32'h58, 1'b0, '0, "R3");
        drive(1'b1, 4'd9, 8'hFF, 2'b00, 6'h00, 1'b0, 1'b1, 1'b1, 32'h59, 1'b0, '0, "R9");
        idle();
        idle();
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule